// File: doc/BRIEF.md
# Paged DMA Transfer Address Generator

This block produces the physical memory address for one DMA channel and keeps track of how many transfers remain. It holds an 8-bit page value and two 16-bit counters, one for the address and one for the remaining count. Each counter has a base copy and a current copy. Software-side logic loads all three values at once. After that, every accepted transfer strobe presents a 24-bit physical address, then steps the address up by one and the count down by one.

The parameter `WORD_CHAN` chooses between two kinds of channel. A byte channel puts the page above the 16-bit address counter, so each page is 64K bytes. A word channel shifts the counter left by one bit and forces address bit 0 to zero. It also discards bit 0 of the page, so each page is 128K bytes. In both kinds the counter wraps inside its page and never carries into the page value.

A terminal-count pulse marks the transfer on which the count passes from zero to all ones. If the auto-restart input is low at that point, the channel goes idle. If it is high, the current address and count are reloaded from their base copies and the channel stays armed.

Top module: `dma_addr_gen`

## Requirements
- R1: While reset is held, and directly after it, `phys_addr` is 0, `cur_count` is 0, `active` is 0 and `tc` is 0.
- R2: A cycle with `load` high copies `ld_page`, `ld_addr` and `ld_count` into the working registers, and also copies `ld_addr` and `ld_count` into their base copies. It sets `active` to 1 in the next cycle.
- R3: On a byte channel (`WORD_CHAN`=0), `phys_addr[23:16]` equals the page and `phys_addr[15:0]` equals the current address counter.
- R4: On a word channel (`WORD_CHAN`=1), `phys_addr[0]` is 0, `phys_addr[16:1]` equals the address counter, and `phys_addr[23:17]` equals page bits 7:1. Page bit 0 has no effect on the address.
- R5: A transfer is accepted when `xfer` is high, `active` is 1 and `load` is low. Each accepted transfer raises the address counter by one, wrapping from 0xFFFF to 0x0000. The page is unchanged by transfers and changes only through `load`.
- R6: Each accepted transfer lowers `cur_count` by one, wrapping from 0x0000 to 0xFFFF. `tc` is high, in the same cycle, exactly on an accepted transfer made while `cur_count` is 0x0000.
- R7: Without auto-restart, `active` is 0 after a `tc` cycle. While `active` is 0, `xfer` has no effect: address, count and `tc` stay put. Cycles with no accepted transfer leave the counters unchanged.
- R8: When `autoinit` is high in a `tc` cycle, the current address and count are reloaded from their base copies on the next cycle, and `active` stays 1.
- R9: When `load` and `xfer` are high in the same cycle, the load wins and no transfer is made.
- R10: A loaded count of N gives exactly N+1 accepted transfers before the channel goes idle. A count of 0x0000 gives 1 transfer and a count of 0xFFFF gives 65536.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load | input | 1 | Load page, address and count (both base and current copies) |
| ld_page | input | 8 | Page value to load |
| ld_addr | input | 16 | Start address to load (in word units on a word channel) |
| ld_count | input | 16 | Number of transfers minus one |
| autoinit | input | 1 | Reload from base copies at terminal count instead of stopping |
| xfer | input | 1 | Transfer strobe |
| phys_addr | output | 24 | Physical address of the current transfer |
| cur_count | output | 16 | Remaining count register |
| active | output | 1 | Channel armed and accepting transfers |
| tc | output | 1 | Terminal count, high on the final accepted transfer |

## Verification
The assertions check on every cycle that the counters step by exactly one on each accepted transfer and hold still otherwise. They also check that the page bits of the address move only on a load, that a word channel never produces an odd address, and that a terminal count leads to the count wrapping and the channel stopping, or to a reload with the channel staying armed. Other behaviours can only be shown by the bench's scenarios. These are the address wrapping across 0xFFFF inside a fixed page, the exact number of transfers for a count of 0 and of 0xFFFF, a load winning over a transfer in the same cycle, and the base values being reused after an auto-restart.

// File: rtl/dma_addr_pkg.sv
package dma_addr_pkg;
  localparam int PAGE_W = 8;
  localparam int CNT_W  = 16;
  localparam int PHYS_W = PAGE_W + CNT_W;

  // Byte channel: page sits above the counter.
  function automatic logic [PHYS_W-1:0] map_byte(input logic [PAGE_W-1:0] page,
                                                 input logic [CNT_W-1:0] cnt);
    return {page, cnt};
  endfunction

  // Word channel: counter shifted up one, page bit 0 discarded.
  function automatic logic [PHYS_W-1:0] map_word(input logic [PAGE_W-1:0] page,
                                                 input logic [CNT_W-1:0] cnt);
    return {page[PAGE_W-1:1], cnt, 1'b0};
  endfunction
endpackage

// File: rtl/dma_cur_base_reg.sv
module dma_cur_base_reg #(
  parameter int W  = 16,
  parameter bit UP = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         step,
  input  logic         reload,
  output logic [W-1:0] cur
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] base_q;
  logic [W-1:0] cur_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      cur_q  <= '0;
    end else if (load) begin
      base_q <= load_val;
      cur_q  <= load_val;
    end else if (reload) begin
      cur_q <= base_q;
    end else if (step) begin
      cur_q <= UP ? cur_q + ONE : cur_q - ONE;
    end
  end

  assign cur = cur_q;

  AST_LOAD_COPIES: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> cur == $past(load_val)); // R2
  AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && !reload) |=> (UP ? (cur - $past(cur)) : ($past(cur) - cur)) == ONE); // R5
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !step && !reload) |=> $stable(cur)); // R7
endmodule

// File: rtl/dma_phys_map.sv
module dma_phys_map
  import dma_addr_pkg::*;
#(
  parameter bit WORD_CHAN = 1'b0
) (
  input  logic [PAGE_W-1:0] page,
  input  logic [CNT_W-1:0]  addr,
  output logic [PHYS_W-1:0] phys
);
  generate
    if (WORD_CHAN) begin : g_word
      assign phys = map_word(page, addr);
    end else begin : g_byte
      assign phys = map_byte(page, addr);
    end
  endgenerate
endmodule

// File: rtl/dma_addr_gen.sv
module dma_addr_gen
  import dma_addr_pkg::*;
#(
  parameter bit WORD_CHAN = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [PAGE_W-1:0] ld_page,
  input  logic [CNT_W-1:0]  ld_addr,
  input  logic [CNT_W-1:0]  ld_count,
  input  logic              autoinit,
  input  logic              xfer,
  output logic [PHYS_W-1:0] phys_addr,
  output logic [CNT_W-1:0]  cur_count,
  output logic              active,
  output logic              tc
);
  logic [PAGE_W-1:0] page_q;
  logic              active_q;
  logic [CNT_W-1:0]  addr_cur;
  logic [CNT_W-1:0]  count_cur;

  // Named internal events
  logic step_evt;    // accepted transfer
  logic tc_evt;      // accepted transfer at count zero
  logic reload_evt;  // auto-restart at terminal count
  logic stop_evt;    // channel goes idle

  assign step_evt   = xfer && active_q && !load;
  assign tc_evt     = step_evt && (count_cur == '0);
  assign reload_evt = tc_evt && autoinit;
  assign stop_evt   = tc_evt && !autoinit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      page_q   <= '0;
      active_q <= 1'b0;
    end else if (load) begin
      page_q   <= ld_page;
      active_q <= 1'b1;
    end else if (stop_evt) begin
      active_q <= 1'b0;
    end
  end

  dma_cur_base_reg #(.W(CNT_W), .UP(1'b1)) u_addr (
    .clk(clk), .rst_n(rst_n), .load(load), .load_val(ld_addr),
    .step(step_evt), .reload(reload_evt), .cur(addr_cur)
  );

  dma_cur_base_reg #(.W(CNT_W), .UP(1'b0)) u_count (
    .clk(clk), .rst_n(rst_n), .load(load), .load_val(ld_count),
    .step(step_evt), .reload(reload_evt), .cur(count_cur)
  );

  dma_phys_map #(.WORD_CHAN(WORD_CHAN)) u_map (
    .page(page_q), .addr(addr_cur), .phys(phys_addr)
  );

  assign cur_count = count_cur;
  assign active    = active_q;
  assign tc        = tc_evt;

  AST_TC_WRAPS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (tc && !autoinit && !load) |=> cur_count == {CNT_W{1'b1}}); // R6
  AST_STOP_AFTER_TC: assert property (@(posedge clk) disable iff (!rst_n)
    (tc && !autoinit && !load) |=> !active); // R7
  AST_IDLE_NO_TC: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> !tc); // R7
  AST_RELOAD_STAYS_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
    (tc && autoinit && !load) |=> active); // R8
  AST_PAGE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(phys_addr[PHYS_W-1:CNT_W+1])); // R5
  AST_LOAD_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> active); // R2

  generate
    if (WORD_CHAN) begin : g_word_chk
      AST_WORD_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
        phys_addr[0] == 1'b0); // R4
    end
  endgenerate
endmodule

// File: tb/dma_addr_gen_tb_top.sv
`timescale 1ns/1ps
module dma_addr_gen_tb_top;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n, load, autoinit, xfer;
  logic [7:0]  ld_page;
  logic [15:0] ld_addr, ld_count;
  logic [23:0] b_phys, w_phys;
  logic [15:0] b_cnt, w_cnt;
  logic        b_act, w_act, b_tc, w_tc;

  dma_addr_gen #(.WORD_CHAN(1'b0)) dut_i (
    .clk(clk), .rst_n(rst_n), .load(load), .ld_page(ld_page), .ld_addr(ld_addr),
    .ld_count(ld_count), .autoinit(autoinit), .xfer(xfer),
    .phys_addr(b_phys), .cur_count(b_cnt), .active(b_act), .tc(b_tc));

  dma_addr_gen #(.WORD_CHAN(1'b1)) dut_w (
    .clk(clk), .rst_n(rst_n), .load(load), .ld_page(ld_page), .ld_addr(ld_addr),
    .ld_count(ld_count), .autoinit(autoinit), .xfer(xfer),
    .phys_addr(w_phys), .cur_count(w_cnt), .active(w_act), .tc(w_tc));

  int checks = 0, errors = 0, tc_seen = 0, cycles = 0;
  bit done = 0;
  // Reference state
  int m_page = 0, m_addr = 0, m_cnt = 0, m_baddr = 0, m_bcnt = 0;
  bit m_act = 0;

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int exp_byte();
    return m_page * 65536 + m_addr;
  endfunction
  function automatic int exp_word();
    return (m_page / 2) * 131072 + m_addr * 2;
  endfunction

  task automatic compare_all(string tag);
    bit stp, t;
    stp = xfer && m_act && !load && rst_n;
    t   = stp && (m_cnt == 0);
    chk({tag, " R3"}, "byte phys", int'(b_phys), exp_byte());
    chk({tag, " R4"}, "word phys", int'(w_phys), exp_word());
    chk({tag, " R6"}, "byte count", int'(b_cnt), m_cnt);
    chk({tag, " R6"}, "word count", int'(w_cnt), m_cnt);
    chk({tag, " R6"}, "byte tc", int'(b_tc), int'(t));
    chk({tag, " R6"}, "word tc", int'(w_tc), int'(t));
    chk({tag, " R2/R7"}, "byte active", int'(b_act), int'(m_act));
    chk({tag, " R2/R7"}, "word active", int'(w_act), int'(m_act));
    if (b_tc) tc_seen++;
  endtask

  task automatic update_model();
    bit stp, t;
    stp = xfer && m_act && !load;
    t   = stp && (m_cnt == 0);
    if (load) begin
      m_page = ld_page; m_addr = ld_addr; m_baddr = ld_addr;
      m_cnt = ld_count; m_bcnt = ld_count; m_act = 1;
    end else if (stp) begin
      if (t && autoinit) begin
        m_addr = m_baddr; m_cnt = m_bcnt;
      end else begin
        m_addr = (m_addr + 1) % 65536;
        m_cnt  = (m_cnt + 65535) % 65536;
      end
      if (t && !autoinit) m_act = 0;
    end
  endtask

  // Called just after a falling edge.
  task automatic cyc(string tag, bit ld, bit xf);
    load = ld; xfer = xf;
    #1;
    compare_all(tag);
    @(posedge clk);
    update_model();
    @(negedge clk);
    load = 0; xfer = 0;
  endtask

  task automatic do_load(string tag, int pg, int ad, int ct, bit au);
    ld_page = 8'(pg); ld_addr = 16'(ad); ld_count = 16'(ct); autoinit = au;
    cyc(tag, 1'b1, 1'b0);
  endtask

  initial begin
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 190000) begin
        errors++;
        $display("FAIL watchdog expired actual=%0d expected<190000", cycles);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    rst_n = 0; load = 0; xfer = 0; autoinit = 0;
    ld_page = 0; ld_addr = 0; ld_count = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    compare_all("reset R1");
    rst_n = 1;
    cyc("after reset R1", 1'b0, 1'b1);  // xfer while idle: ignored

    // Byte/word mapping and wrap inside the page
    do_load("load R2", 'h12, 'hFFFE, 3, 1'b0);
    cyc("xfer", 1'b0, 1'b1);
    cyc("xfer wrap", 1'b0, 1'b1);
    chk("R5", "byte wrap stays in page", int'(b_phys), 'h120000);
    chk("R5", "word wrap stays in page", int'(w_phys), 'h120000);
    cyc("idle gap R7", 1'b0, 1'b0);
    cyc("xfer", 1'b0, 1'b1);
    cyc("last xfer", 1'b0, 1'b1);
    chk("R7", "stopped after tc", int'(b_act), 0);
    for (int i = 0; i < 3; i++) cyc("ignored R7", 1'b0, 1'b1);
    chk("R7", "count held while idle", int'(b_cnt), 'hFFFF);

    // Odd page: word channel drops page bit 0; auto-restart
    do_load("load odd page R4", 'h35, 'h1000, 1, 1'b1);
    chk("R4", "word page bit0 dropped", int'(w_phys), 'h342000);
    for (int i = 0; i < 7; i++) cyc("autoinit R8", 1'b0, (i % 3) != 1);
    cyc("autoinit R8", 1'b0, 1'b0);
    chk("R8", "still armed", int'(b_act), 1);

    // Load beats transfer in the same cycle
    ld_page = 8'h80; ld_addr = 16'h0040; ld_count = 16'd5; autoinit = 1'b0;
    cyc("load+xfer R9", 1'b1, 1'b1);
    chk("R9", "count from load", int'(b_cnt), 5);
    chk("R9", "address from load", int'(b_phys), 'h800040);

    // Count 0: one transfer
    do_load("load zero R10", 'h01, 'h0007, 0, 1'b0);
    tc_seen = 0;
    cyc("single R10", 1'b0, 1'b1);
    cyc("after single R10", 1'b0, 1'b1);
    chk("R10", "one transfer for count 0", tc_seen, 1);
    chk("R10", "idle after single", int'(b_act), 0);

    // Count 0xFFFF: 65536 transfers
    do_load("load max R10", 'hFF, 'h0000, 'hFFFF, 1'b0);
    tc_seen = 0;
    for (int i = 0; i < 65535; i++) cyc("long run", 1'b0, 1'b1);
    chk("R10", "no tc before 65536th", tc_seen, 0);
    chk("R10", "still armed before last", int'(b_act), 1);
    cyc("long last", 1'b0, 1'b1);
    chk("R10", "tc on 65536th", tc_seen, 1);
    chk("R10", "idle after 65536", int'(b_act), 0);
    chk("R5", "address wrapped to page base", int'(b_phys), 'hFF0000);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule